// File: doc/BRIEF.md
# Interrupt-Driven Single-Move Transfer Engine

This block answers a peripheral's service request with one data move instead of a full interrupt routine. It has eight channels. Each channel holds a source pointer, a destination pointer and a control word. A trigger on a channel makes the engine take one bus cycle. In that cycle it reads a byte or a word at the source pointer and writes it to the destination pointer. It then advances one of the two pointers and counts down the channel's transfer budget.

A channel whose budget is already used up does no move when it is triggered. It raises a normal interrupt request for its own source, so that software can refill it or finish the block transfer. A budget value of all ones marks a channel that never runs out. Software programs the channels through a small register port, and the memory side is a single-cycle port with a combinational read and a write that takes effect at the clock edge.

Top module: `evt_mover`

## Requirements
- R1: There are eight channels. A one-cycle pulse on `trig_i[n]` sets a pending flag for channel n, and the flag stays set until that channel is served. Channels triggered in the same cycle are each served exactly once.
- R2: At most one channel is served per cycle, and among pending channels the lowest index goes first. A channel triggered at clock edge k is latched at edge k and served in the cycle that ends at edge k+1, if no lower channel is waiting.
- R3: In a transfer cycle `mem_we` is high for that single cycle, `mem_raddr` equals the channel's source pointer and `mem_waddr` equals its destination pointer. With control bit 10 at 0 all 16 bits of `mem_rdata` are written and `mem_wbyte` is 0. With bit 10 at 1 only bits 7:0 are written and `mem_wbyte` is 1.
- R4: Control bits 9:8 choose which pointer moves after a transfer: 01 moves the source, 10 moves the destination, and 00 or 11 moves neither. The step is 1 for a byte and 2 for a word.
- R5: Control bits 7:0 hold the transfer budget, which drops by one on each transfer. The value 0xFF means continuous mode, and the budget then never changes.
- R6: When a channel with a budget of 0 is served, no memory write happens and its pointers and budget stay unchanged. `irq_o[n]` pulses for one cycle, in the cycle after the service slot, and `done_o[n]` stays low.
- R7: After each transfer, `done_o[n]` is high for exactly the one cycle that follows the write.
- R8: Register access uses `cfg_sel`: 0 selects the control word (bits 10:0), 1 the source pointer and 2 the destination pointer, and 3 reads as zero. A write happens at the clock edge while `cfg_we` is high. `cfg_rdata` shows the register selected by `cfg_ch` and `cfg_sel` without delay. Every register is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | N_CH | Per-channel service request pulses |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel addressed by the register port |
| cfg_sel | input | 2 | Register select: control, source, destination |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Selected register contents |
| mem_raddr | output | ADDR_W | Memory read address (source pointer) |
| mem_rdata | input | 16 | Memory read data, little-endian word |
| mem_we | output | 1 | Memory write strobe for the transfer cycle |
| mem_waddr | output | ADDR_W | Memory write address (destination pointer) |
| mem_wdata | output | 16 | Memory write data |
| mem_wbyte | output | 1 | 1 = write bits 7:0 only, 0 = full word |
| done_o | output | N_CH | One-cycle pulse after a channel's transfer |
| irq_o | output | N_CH | One-cycle standard interrupt request on exhaustion |

## Verification
The checker watches every cycle for these rules: at most one channel is granted, and only a channel that is pending. No lower pending channel is ever passed over. Every write is followed by exactly one done pulse, and every done pulse follows a write. An interrupt pulse never comes right after a write, and it never shares a cycle with a done pulse. Only the bench scenarios can show the moved data, the pointer steps for each step code and size, how the budget counts down, that continuous mode holds its value, and the cycle-exact order in which simultaneous triggers are served.

// File: rtl/evt_mover_pkg.sv
package evt_mover_pkg;

  localparam int CNT_W  = 8;
  localparam int CTRL_W = CNT_W + 3;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_SRC  = 2'b01,
    STEP_DST  = 2'b10,
    STEP_OFF  = 2'b11
  } step_sel_e;

  typedef struct packed {
    logic            byte_mode;
    step_sel_e       step;
    logic [CNT_W-1:0] count;
  } chan_ctrl_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;

  localparam logic [CNT_W-1:0] CNT_CONT = {CNT_W{1'b1}};

  // Budget after one transfer: continuous value is sticky.
  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] c);
    return (c == CNT_CONT) ? c : c - 1'b1;
  endfunction

  // Pointer stride in bytes for one transfer.
  function automatic logic [1:0] stride_of(input logic byte_mode);
    return byte_mode ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/evt_mover_pend.sv
module evt_mover_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q
);
  // A new trigger wins over the clear of the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | trig;
  end
endmodule

// File: rtl/evt_mover_arb.sv
module evt_mover_arb #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_mover_chan.sv
module evt_mover_chan
  import evt_mover_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              xfer,
  output chan_ctrl_t        ctrl_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q
);
  logic [ADDR_W-1:0] stride;
  assign stride = ADDR_W'(stride_of(ctrl_q.byte_mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q       <= chan_ctrl_t'(wdata[CTRL_W-1:0]);
      else if (xfer) ctrl_q.count <= count_after(ctrl_q.count);

      if (wr_src)                            src_q <= wdata;
      else if (xfer && ctrl_q.step == STEP_SRC) src_q <= src_q + stride;

      if (wr_dst)                            dst_q <= wdata;
      else if (xfer && ctrl_q.step == STEP_DST) dst_q <= dst_q + stride;
    end
  end
endmodule

// File: rtl/evt_mover.sv
module evt_mover
  import evt_mover_pkg::*;
#(
  parameter  int N_CH   = 8,
  parameter  int ADDR_W = 16,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   trig_i,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wbyte,
  output logic [N_CH-1:0]   done_o,
  output logic [N_CH-1:0]   irq_o
);
  // Named internal events, also seen by the bound checker.
  logic [N_CH-1:0] pend_q;
  logic [N_CH-1:0] grant_vec;
  logic [CH_W-1:0] svc_idx;
  logic            svc_any;
  logic            svc_exhausted;
  logic            xfer_fire;
  logic [N_CH-1:0] xfer_vec;

  chan_ctrl_t        ctrl_a [N_CH];
  logic [ADDR_W-1:0] src_a  [N_CH];
  logic [ADDR_W-1:0] dst_a  [N_CH];
  chan_ctrl_t        svc_ctrl;

  evt_mover_pend #(.N(N_CH)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig_i),
    .clr    (grant_vec),
    .pend_q (pend_q)
  );

  evt_mover_arb #(.N(N_CH)) u_arb (
    .req (pend_q),
    .gnt (grant_vec),
    .idx (svc_idx),
    .any (svc_any)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    evt_mover_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (cfg_we && cfg_ch == CH_W'(g) && cfg_sel == SEL_CTRL),
      .wr_src  (cfg_we && cfg_ch == CH_W'(g) && cfg_sel == SEL_SRC),
      .wr_dst  (cfg_we && cfg_ch == CH_W'(g) && cfg_sel == SEL_DST),
      .wdata   (cfg_wdata),
      .xfer    (xfer_vec[g]),
      .ctrl_q  (ctrl_a[g]),
      .src_q   (src_a[g]),
      .dst_q   (dst_a[g])
    );
  end

  // Service slot: the granted channel moves or, when spent, interrupts.
  assign svc_ctrl      = ctrl_a[svc_idx];
  assign svc_exhausted = svc_any && (svc_ctrl.count == '0);
  assign xfer_fire     = svc_any && !svc_exhausted;
  assign xfer_vec      = xfer_fire ? grant_vec : '0;

  assign mem_raddr = src_a[svc_idx];
  assign mem_waddr = dst_a[svc_idx];
  assign mem_we    = xfer_fire;
  assign mem_wbyte = svc_ctrl.byte_mode;
  assign mem_wdata = svc_ctrl.byte_mode ? {8'h00, mem_rdata[7:0]} : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= '0;
      irq_o  <= '0;
    end else begin
      done_o <= xfer_vec;
      irq_o  <= svc_exhausted ? grant_vec : '0;
    end
  end

  always_comb begin
    unique case (cfg_sel)
      SEL_CTRL: cfg_rdata = {{(ADDR_W-CTRL_W){1'b0}}, ctrl_a[cfg_ch]};
      SEL_SRC:  cfg_rdata = src_a[cfg_ch];
      SEL_DST:  cfg_rdata = dst_a[cfg_ch];
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_mover_chk.sv
module evt_mover_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] grant_vec,
  input logic [N_CH-1:0] pend_q,
  input logic            mem_we,
  input logic [N_CH-1:0] done_o,
  input logic [N_CH-1:0] irq_o
);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_grant_is_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~pend_q) == '0);

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_vec) |-> (((grant_vec - 1'b1) & pend_q) == '0));

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ($countones(done_o) == 1));

  p_done_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |-> $past(mem_we));

  p_no_write_before_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> !$past(mem_we));

  p_irq_done_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|irq_o) && (|done_o)));
endmodule

bind evt_mover evt_mover_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant_vec (grant_vec),
  .pend_q    (pend_q),
  .mem_we    (mem_we),
  .done_o    (done_o),
  .irq_o     (irq_o)
);

// File: tb/evt_mover_bench.sv
module evt_mover_bench;
  localparam int N_CH = 8;
  localparam int AW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    trig_i = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_ch = '0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata, mem_raddr, mem_waddr;
  logic [15:0]   mem_rdata, mem_wdata;
  logic          mem_we, mem_wbyte;
  logic [7:0]    done_o, irq_o;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  bit finished = 0;
  int done_at [8];
  int irq_at  [8];
  int done_n  [8];

  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  evt_mover u_evt_mover (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wbyte(mem_wbyte),
    .done_o(done_o), .irq_o(irq_o)
  );

  // Byte-addressed little-endian memory model.
  assign mem_rdata = {mem[8'(mem_raddr + 16'd1)], mem[mem_raddr[7:0]]};
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      writes <= writes + 1;
      mem[mem_waddr[7:0]] <= mem_wdata[7:0];
      if (!mem_wbyte) mem[8'(mem_waddr + 16'd1)] <= mem_wdata[15:8];
    end
  end

  function automatic logic [15:0] ctl(input bit is_byte, input logic [1:0] step, input logic [7:0] cnt);
    return {5'b0, is_byte, step, cnt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    cfg_ch = 3'(ch); cfg_sel = sel;
    #1 val = cfg_rdata;
  endtask

  // Pulse triggers, then log per-channel pulse cycles (cycle 1 = first service slot result).
  task automatic fire(input logic [7:0] mask);
    for (int i = 0; i < 8; i++) begin done_at[i] = -1; irq_at[i] = -1; done_n[i] = 0; end
    @(negedge clk);
    trig_i = mask;
    for (int cyc = 0; cyc < 10; cyc++) begin
      @(negedge clk);
      if (cyc == 0) trig_i = '0;
      for (int i = 0; i < 8; i++) begin
        if (done_o[i]) begin done_n[i]++; if (done_at[i] < 0) done_at[i] = cyc; end
        if (irq_o[i] && irq_at[i] < 0) irq_at[i] = cyc;
      end
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R8 done after reset", 32'(done_o), 0);
    chk("R8 irq after reset", 32'(irq_o), 0);
    chk("R3 no write after reset", 32'(mem_we), 0);
    for (int ch = 0; ch < 8; ch += 3) begin
      rd(ch, 2'd0, v); chk("R8 ctrl reset", 32'(v), 0);
      rd(ch, 2'd1, v); chk("R8 src reset", 32'(v), 0);
      rd(ch, 2'd2, v); chk("R8 dst reset", 32'(v), 0);
    end
  endtask

  task automatic t_word_src;
    logic [15:0] v;
    mem[8'h10] = 8'hAB; mem[8'h11] = 8'hCD;
    wr(2, 2'd0, ctl(0, 2'b01, 8'd3));
    wr(2, 2'd1, 16'h0010);
    wr(2, 2'd2, 16'h0080);
    rd(2, 2'd3, v); chk("R8 select 3 reads zero", 32'(v), 0);
    fire(8'h04);
    chk("R7 done slot ch2", 32'(done_at[2]), 1);
    chk("R7 single done ch2", 32'(done_n[2]), 1);
    chk("R3 word low byte", 32'(mem[8'h80]), 32'hAB);
    chk("R3 word high byte", 32'(mem[8'h81]), 32'hCD);
    rd(2, 2'd1, v); chk("R4 source stepped by 2", 32'(v), 32'h12);
    rd(2, 2'd2, v); chk("R4 destination held", 32'(v), 32'h80);
    rd(2, 2'd0, v); chk("R5 budget down by one", 32'(v), 32'(ctl(0, 2'b01, 8'd2)));
  endtask

  task automatic t_byte_dst;
    logic [15:0] v;
    mem[8'h20] = 8'h5A; mem[8'h21] = 8'h77; mem[8'h91] = 8'hEE;
    wr(5, 2'd0, ctl(1, 2'b10, 8'd5));
    wr(5, 2'd1, 16'h0020);
    wr(5, 2'd2, 16'h0090);
    fire(8'h20);
    chk("R3 byte moved", 32'(mem[8'h90]), 32'h5A);
    chk("R3 byte neighbour untouched", 32'(mem[8'h91]), 32'hEE);
    rd(5, 2'd2, v); chk("R4 destination stepped by 1", 32'(v), 32'h91);
    rd(5, 2'd1, v); chk("R4 source held", 32'(v), 32'h20);
    rd(5, 2'd0, v); chk("R5 byte budget", 32'(v), 32'(ctl(1, 2'b10, 8'd4)));
  endtask

  task automatic t_continuous;
    logic [15:0] v;
    wr(0, 2'd0, ctl(0, 2'b01, 8'hFF));
    wr(0, 2'd1, 16'h0040);
    wr(0, 2'd2, 16'h00C0);
    fire(8'h01);
    fire(8'h01);
    rd(0, 2'd0, v); chk("R5 continuous budget fixed", 32'(v), 32'(ctl(0, 2'b01, 8'hFF)));
    rd(0, 2'd1, v); chk("R5 continuous still moves", 32'(v), 32'h44);
  endtask

  task automatic t_exhaust;
    logic [15:0] v;
    int w0;
    wr(7, 2'd0, ctl(0, 2'b01, 8'd1));
    wr(7, 2'd1, 16'h0030);
    wr(7, 2'd2, 16'h00A0);
    fire(8'h80);
    chk("R7 last transfer done", 32'(done_n[7]), 1);
    chk("R6 no irq while budget left", 32'(irq_at[7]), 32'hFFFFFFFF);
    w0 = writes;
    fire(8'h80);
    chk("R6 irq slot ch7", 32'(irq_at[7]), 1);
    chk("R6 no done when spent", 32'(done_n[7]), 0);
    chk("R6 no memory write", 32'(writes - w0), 0);
    rd(7, 2'd1, v); chk("R6 source unchanged", 32'(v), 32'h32);
    rd(7, 2'd0, v); chk("R6 budget stays zero", 32'(v), 32'(ctl(0, 2'b01, 8'd0)));
  endtask

  task automatic t_priority;
    logic [15:0] v;
    int w0;
    wr(1, 2'd0, ctl(0, 2'b00, 8'd2)); wr(1, 2'd1, 16'h0050); wr(1, 2'd2, 16'h00D0);
    wr(3, 2'd0, ctl(0, 2'b11, 8'd2)); wr(3, 2'd1, 16'h0052); wr(3, 2'd2, 16'h00D2);
    wr(6, 2'd0, ctl(1, 2'b00, 8'd2)); wr(6, 2'd1, 16'h0054); wr(6, 2'd2, 16'h00D4);
    w0 = writes;
    fire(8'h4A);
    chk("R2 ch1 first", 32'(done_at[1]), 1);
    chk("R2 ch3 second", 32'(done_at[3]), 2);
    chk("R2 ch6 third", 32'(done_at[6]), 3);
    chk("R1 ch1 served once", 32'(done_n[1]), 1);
    chk("R1 ch3 served once", 32'(done_n[3]), 1);
    chk("R1 ch6 served once", 32'(done_n[6]), 1);
    chk("R1 three writes", 32'(writes - w0), 3);
    rd(1, 2'd1, v); chk("R4 step 00 holds source", 32'(v), 32'h50);
    rd(3, 2'd2, v); chk("R4 step 11 holds destination", 32'(v), 32'hD2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h3C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_src();
    t_byte_dst();
    t_continuous();
    t_exhaust();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule